// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of an 8-bit successive-approximation converter with six multiplexed analog inputs. Software loads a clock configuration (a 2-bit prescaler code and a clock-select bit). It then issues a start strobe with a channel number. From that point the sequencer takes over. It drives the channel number onto the multiplexer bus and holds a sample-enable strobe for the sampling window. It then builds the output code one bit at a time, most significant bit first, against a single comparator input. Finally it pads the conversion out to its fixed length and publishes the code.

The conversion clock comes from two dividers in series. The first divides the system clock by 2, 4 or 16 to make a base clock. The second either passes that base clock through or halves it again. Every conversion spends 12 conversion-clock periods sampling, and takes 160 conversion-clock periods in total. At the end, the result register updates, busy drops, a sticky done flag rises and a one-cycle interrupt pulse is issued.

Top module: `sar_sequencer`

## Requirements
- R1: A synchronous reset clears the result to 00h, clears busy, done and the interrupt, and selects prescaler code 00 with clock-select 0, which is a conversion period of 4 system clocks.
- R2: A `cfgWr` strobe loads `prescCode` and `clkSel`. The prescaler code sets the base clock: code 00 divides the system clock by 2, code 01 by 4, and code 11 by 16. Reserved code 10 acts exactly like code 11.
- R3: With `clkSel` = 0 the conversion clock is the base clock divided by 2. With `clkSel` = 1 it equals the base clock.
- R4: An accepted start raises busy on the same clock edge. Busy then stays high for exactly 160 conversion-clock periods (160·P system clocks, where P is the conversion period in system clocks).
- R5: `sampleEn` is high for exactly the first 12 conversion-clock periods of each conversion and is never high while idle.
- R6: The code is decided MSB first. Each trial bit is kept when `cmpIn` is 1 (input at or above the trial code) and cleared when it is 0. The result is therefore the largest code not above the input: 00h for zero input, FFh at full scale.
- R7: Channel numbers 0 to 5 appear unchanged on `muxSel`. Numbers 6 and 7 select channel 0.
- R8: The channel is captured at start, and `muxSel` stays constant for the whole conversion whatever `chanSel` does later.
- R9: A start strobe while busy is ignored. The running conversion keeps its channel, its timing and its result.
- R10: At the end of a conversion the result register updates, busy clears and done sets. `irq` is high for exactly one system clock. Done stays set, and the result holds, until the next accepted start, which clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| startStb | input | 1 | One-cycle conversion start request |
| chanSel | input | 3 | Channel number sampled at start |
| cfgWr | input | 1 | Load strobe for the clock configuration |
| prescCode | input | 2 | Base-clock prescaler code |
| clkSel | input | 1 | 1: conversion clock equals base clock, 0: base clock halved |
| cmpIn | input | 1 | Comparator decision, 1 when the input is at or above `trialCode` |
| muxSel | output | 3 | Channel select for the analog multiplexer |
| sampleEn | output | 1 | Sample-and-hold enable |
| trialCode | output | 8 | Code applied to the internal DAC |
| resultCode | output | 8 | Last completed conversion result |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Sticky conversion-complete flag |
| irq | output | 1 | One-cycle end-of-conversion interrupt |

## Verification
On every cycle, the embedded properties check the following: the interrupt lasts a single cycle; done and busy are never high together; sampling happens only while busy; the channel bus stays legal and constant during a conversion; a start while busy leaves it untouched; and the result register changes only at the finish strobe. The exact conversion lengths for each prescaler and clock-select combination, the 12-period sampling window, the reserved-code alias and the correctness of the binary search against an input level can only be shown by the bench. Its comparator model answers from per-channel input levels, and its scoreboard compares the published code, the busy and sample durations and the channel used with values it computes itself.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int RES_W = 8;
  localparam int BIT_W = $clog2(RES_W);

  // control-to-datapath strobes
  typedef struct packed {
    logic             clear;
    logic             setMsb;
    logic             decide;
    logic [BIT_W-1:0] bitIdx;
    logic             finish;
  } seqStrb_t;
endpackage

// File: rtl/sar_clkdiv.sv
module sar_clkdiv #(
  parameter int PHI_DIV_LO  = 2,
  parameter int PHI_DIV_MID = 4,
  parameter int PHI_DIV_HI  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cfgWr,
  input  logic [1:0] prescCode,
  input  logic       clkSel,
  input  logic       run,
  output logic       convTick
);
  localparam int PRE_W = $clog2(PHI_DIV_HI);

  logic [1:0]       prescR;
  logic             selR;
  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] phiLim;
  logic             half;
  logic             phiTick;

  always_ff @(posedge clk) begin
    if (rst) begin
      prescR <= 2'b00;
      selR   <= 1'b0;
    end else if (cfgWr) begin
      prescR <= prescCode;
      selR   <= clkSel;
    end
  end

  always_comb begin
    case (prescR)
      2'b00:   phiLim = PRE_W'(PHI_DIV_LO - 1);
      2'b01:   phiLim = PRE_W'(PHI_DIV_MID - 1);
      default: phiLim = PRE_W'(PHI_DIV_HI - 1);  // 10 aliases 11
    endcase
  end

  // first stage: base clock prescaler
  always_ff @(posedge clk) begin
    if (rst || !run) begin
      preCnt <= '0;
      half   <= 1'b0;
    end else if (preCnt == phiLim) begin
      preCnt <= '0;
      half   <= ~half;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end

  assign phiTick  = run && (preCnt == phiLim);
  // second stage: pass-through or halve
  assign convTick = phiTick && (selR || half);

  AST_TICK_HALF_GAP: assert property (@(posedge clk) disable iff (rst)
    (convTick && !selR) |=> !convTick);  // R3
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl import sar_seq_pkg::*; #(
  parameter int NUM_CH       = 6,
  parameter int SAMPLE_STEPS = 12,
  parameter int TOTAL_STEPS  = 160
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        startStb,
  input  logic [$clog2(NUM_CH)-1:0]   chanSel,
  input  logic                        convTick,
  output seqStrb_t                    strb,
  output logic [$clog2(NUM_CH)-1:0]   muxSel,
  output logic                        sampleEn,
  output logic                        busy,
  output logic                        done,
  output logic                        irq
);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int STEP_W = $clog2(TOTAL_STEPS);

  logic              busyR, doneR, irqR;
  logic [STEP_W-1:0] stepCnt;
  logic [CH_W-1:0]   chanR;
  logic              startOk;
  logic              lastStep;

  assign startOk  = startStb && !busyR;
  assign lastStep = busyR && convTick && (stepCnt == STEP_W'(TOTAL_STEPS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      irqR    <= 1'b0;
      stepCnt <= '0;
      chanR   <= '0;
    end else begin
      irqR <= 1'b0;
      if (startOk) begin
        busyR   <= 1'b1;
        doneR   <= 1'b0;
        stepCnt <= '0;
        chanR   <= (chanSel < CH_W'(NUM_CH)) ? chanSel : '0;
      end else if (lastStep) begin
        busyR   <= 1'b0;
        doneR   <= 1'b1;
        irqR    <= 1'b1;
        stepCnt <= '0;
      end else if (busyR && convTick) begin
        stepCnt <= stepCnt + STEP_W'(1);
      end
    end
  end

  always_comb begin
    strb.clear  = startOk;
    strb.setMsb = busyR && convTick && (stepCnt == STEP_W'(SAMPLE_STEPS - 1));
    strb.decide = busyR && convTick &&
                  (stepCnt >= STEP_W'(SAMPLE_STEPS)) &&
                  (stepCnt <  STEP_W'(SAMPLE_STEPS + RES_W));
    // modulo arithmetic: first trial step maps to the MSB index
    strb.bitIdx = BIT_W'(SAMPLE_STEPS + RES_W - 1) - stepCnt[BIT_W-1:0];
    strb.finish = lastStep;
  end

  assign muxSel   = chanR;
  assign sampleEn = busyR && (stepCnt < STEP_W'(SAMPLE_STEPS));
  assign busy     = busyR;
  assign done     = doneR;
  assign irq      = irqR;

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);  // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);  // R10
  AST_SAMPLE_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    sampleEn |-> busy);  // R5
  AST_CHAN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    muxSel < CH_W'(NUM_CH));  // R7
  AST_CHAN_HELD: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(muxSel));  // R8
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && startStb) |=> ($stable(muxSel) && !($fell(done))));  // R9
endmodule

// File: rtl/sar_datapath.sv
module sar_datapath import sar_seq_pkg::*; (
  input  logic             clk,
  input  logic             rst,
  input  seqStrb_t         strb,
  input  logic             cmpIn,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] resultCode
);
  logic [RES_W-1:0] trialR;
  logic [RES_W-1:0] resultR;

  always_ff @(posedge clk) begin
    if (rst) begin
      trialR <= '0;
    end else if (strb.clear) begin
      trialR <= '0;
    end else begin
      if (strb.setMsb)
        trialR[RES_W-1] <= 1'b1;
      if (strb.decide) begin
        trialR[strb.bitIdx] <= cmpIn;
        if (strb.bitIdx != '0)
          trialR[strb.bitIdx - BIT_W'(1)] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      resultR <= '0;
    else if (strb.finish)
      resultR <= trialR;
  end

  assign trialCode  = trialR;
  assign resultCode = resultR;

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !strb.finish |=> $stable(resultCode));  // R10
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (rst)
    $countones({strb.clear, strb.setMsb, strb.decide, strb.finish}) <= 1);  // R6
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer import sar_seq_pkg::*; #(
  parameter int NUM_CH       = 6,
  parameter int SAMPLE_STEPS = 12,
  parameter int TOTAL_STEPS  = 160,
  parameter int PHI_DIV_LO   = 2,
  parameter int PHI_DIV_MID  = 4,
  parameter int PHI_DIV_HI   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startStb,
  input  logic [2:0]       chanSel,
  input  logic             cfgWr,
  input  logic [1:0]       prescCode,
  input  logic             clkSel,
  input  logic             cmpIn,
  output logic [2:0]       muxSel,
  output logic             sampleEn,
  output logic [RES_W-1:0] trialCode,
  output logic [RES_W-1:0] resultCode,
  output logic             busy,
  output logic             done,
  output logic             irq
);
  seqStrb_t strb;
  logic     convTick;

  sar_clkdiv #(
    .PHI_DIV_LO (PHI_DIV_LO),
    .PHI_DIV_MID(PHI_DIV_MID),
    .PHI_DIV_HI (PHI_DIV_HI)
  ) u_clkdiv (
    .clk      (clk),
    .rst      (rst),
    .cfgWr    (cfgWr),
    .prescCode(prescCode),
    .clkSel   (clkSel),
    .run      (busy),
    .convTick (convTick)
  );

  sar_ctrl #(
    .NUM_CH      (NUM_CH),
    .SAMPLE_STEPS(SAMPLE_STEPS),
    .TOTAL_STEPS (TOTAL_STEPS)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .startStb(startStb),
    .chanSel (chanSel),
    .convTick(convTick),
    .strb    (strb),
    .muxSel  (muxSel),
    .sampleEn(sampleEn),
    .busy    (busy),
    .done    (done),
    .irq     (irq)
  );

  sar_datapath u_dp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .cmpIn     (cmpIn),
    .trialCode (trialCode),
    .resultCode(resultCode)
  );
endmodule

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startStb = 1'b0;
  logic [2:0] chanSel = 3'd0;
  logic       cfgWr = 1'b0;
  logic [1:0] prescCode = 2'b00;
  logic       clkSel = 1'b0;
  logic       cmpIn;
  logic [2:0] muxSel;
  logic       sampleEn;
  logic [7:0] trialCode, resultCode;
  logic       busy, done, irq;

  logic [7:0] vinArr [8];

  typedef struct { int res; int cyc; int smp; int ch; string tag; } exp_t;
  exp_t q[$];

  int checks = 0;
  int fails  = 0;
  int doneCnt = 0;
  int busyCnt = 0;
  int smpCnt  = 0;
  logic prevIrq = 1'b0;

  always #2 clk = ~clk;

  sar_sequencer u_sar_sequencer (
    .clk(clk), .rst(rst), .startStb(startStb), .chanSel(chanSel),
    .cfgWr(cfgWr), .prescCode(prescCode), .clkSel(clkSel), .cmpIn(cmpIn),
    .muxSel(muxSel), .sampleEn(sampleEn), .trialCode(trialCode),
    .resultCode(resultCode), .busy(busy), .done(done), .irq(irq)
  );

  // comparator model: input level at or above the trial code
  assign cmpIn = (vinArr[muxSel] >= trialCode);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int periodOf(input logic [1:0] code, input logic sel);
    int phi;
    phi = (code == 2'b00) ? 2 : (code == 2'b01) ? 4 : 16;
    return sel ? phi : 2 * phi;
  endfunction

  task automatic setCfg(input logic [1:0] code, input logic sel);
    @(negedge clk);
    cfgWr = 1'b1; prescCode = code; clkSel = sel;
    @(negedge clk);
    cfgWr = 1'b0; prescCode = 2'b00; clkSel = 1'b0;
  endtask

  task automatic pulseStart(input logic [2:0] ch);
    @(negedge clk);
    startStb = 1'b1; chanSel = ch;
    @(negedge clk);
    startStb = 1'b0; chanSel = 3'd7;
  endtask

  // driver: push expectation, start, wait for the monitor
  task automatic runConv(input logic [2:0] ch, input int per, input string tag);
    exp_t e;
    int eff;
    eff = (ch > 3'd5) ? 0 : int'(ch);
    e.res = int'(vinArr[eff]); e.cyc = 160 * per; e.smp = 12 * per;
    e.ch = eff; e.tag = tag;
    q.push_back(e);
    pulseStart(ch);
    wait (doneCnt == checksTarget());
  endtask

  int issued = 0;
  function automatic int checksTarget();
    return issued;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (prevIrq) check(!irq, "R10 irq one cycle", int'(irq), 0);
      if (busy) busyCnt++;
      if (sampleEn) smpCnt++;
      if (irq) begin
        if (q.size() == 0) begin
          check(1'b0, "R9 unexpected completion", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(int'(resultCode) == e.res, {"R6 result ", e.tag}, int'(resultCode), e.res);
          check(busyCnt == e.cyc, {"R4 busy length ", e.tag}, busyCnt, e.cyc);
          check(smpCnt == e.smp, {"R5 sample length ", e.tag}, smpCnt, e.smp);
          check(int'(muxSel) == e.ch, {"R7 R8 channel ", e.tag}, int'(muxSel), e.ch);
          check(done && !busy, {"R10 flags ", e.tag}, int'({done, busy}), 2);
        end
        busyCnt = 0;
        smpCnt = 0;
        doneCnt++;
      end
      prevIrq = irq;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", doneCnt, issued);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic conv(input logic [2:0] ch, input int per, input string tag);
    issued++;
    runConv(ch, per, tag);
  endtask

  initial begin
    vinArr[0] = 8'h3C; vinArr[1] = 8'h7F; vinArr[2] = 8'h5A; vinArr[3] = 8'h80;
    vinArr[4] = 8'h01; vinArr[5] = 8'hFF; vinArr[6] = 8'h11; vinArr[7] = 8'h22;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(resultCode == 8'h00, "R1 result", int'(resultCode), 0);
    check({busy, done, irq, sampleEn} == 4'b0000, "R1 flags", int'({busy, done, irq, sampleEn}), 0);

    // R1 R2 R3: default configuration period 4
    conv(3'd2, 4, "default cfg");
    // R2: code 01 with halving, full scale
    setCfg(2'b01, 1'b0);
    conv(3'd5, 8, "code01 sel0");
    // R2 R3: code 11 pass-through
    vinArr[0] = 8'h00;
    setCfg(2'b11, 1'b1);
    conv(3'd0, 16, "code11 sel1 zero input");
    // R2: reserved code 10 like 11
    setCfg(2'b10, 1'b1);
    conv(3'd3, 16, "code10 alias");
    // R3: fastest setting
    setCfg(2'b00, 1'b1);
    conv(3'd1, 2, "code00 sel1");
    setCfg(2'b01, 1'b1);
    conv(3'd4, 4, "code01 sel1");
    // R7: out-of-range channels fall back to channel 0
    vinArr[0] = 8'hA7;
    conv(3'd6, 4, "chan6");
    conv(3'd7, 4, "chan7");

    // R10: done sticky and result held
    repeat (20) @(negedge clk);
    check(done == 1'b1, "R10 done sticky", int'(done), 1);
    check(resultCode == 8'hA7, "R10 result held", int'(resultCode), 32'hA7);

    // R8 R9: start while busy is ignored; R10 done clears on start
    setCfg(2'b00, 1'b0);
    issued++;
    begin
      exp_t e;
      e.res = int'(vinArr[1]); e.cyc = 640; e.smp = 48; e.ch = 1; e.tag = "busy restart";
      q.push_back(e);
    end
    pulseStart(3'd1);
    check(done == 1'b0, "R10 done cleared by start", int'(done), 0);
    check(busy == 1'b1, "R4 busy on start", int'(busy), 1);
    repeat (100) @(negedge clk);
    pulseStart(3'd4);
    wait (doneCnt == issued);

    // R3: slowest setting
    setCfg(2'b11, 1'b0);
    conv(3'd2, 32, "code11 sel0");

    repeat (5) @(negedge clk);
    check(q.size() == 0, "R9 no extra results", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule